// File: doc/BRIEF.md
# CAN Operating-Mode Control and Bus Integration

This block keeps the operating-mode word of a CAN controller and decides when the controller may take part in bus traffic. Software reads and writes the word through a simple register port. A hardware reset or a bus-off report from the error logic parks the controller in soft reset. While in soft reset, no traffic is possible and the configuration bits may be changed.

Once software clears the soft reset bit, the block watches the sampled receive line. It counts runs of eleven recessive bits, called bus-free occurrences. It declares bus-on after one such occurrence when the last reset came from hardware or software. It needs 128 occurrences when the last reset was caused by bus-off. The block also applies the selected pin polarity: it decodes the receive pin into a dominant flag and drives the transmit pin. The transmit pin is held recessive whenever the controller is not on the bus or is only listening.

Top module: `can_mode_ctrl`

## Requirements
- R1: The read word places soft reset at bit 0, listen-only at bit 1, self-test at bit 2, transmit priority mode at bit 3 and reverse polarity at bit 5. Bit 4 and bits 31 down to 6 always read 0.
- R2: After hardware reset (`rst_n` low), the read word is 0x00000001 and `bus_on` is 0.
- R3: When `bus_off` is high at a clock edge, soft reset is 1 and `bus_on` is 0 from the next cycle on. A register write in that same cycle is discarded.
- R4: Bits 1, 2, 3 and 5 take the written value only when soft reset is already 1 in the cycle of the write; otherwise they keep their value. Bit 0 takes the written value on every write.
- R5: A bus-free occurrence is 11 consecutive `bit_stb` cycles with a recessive receive bit. A strobe with a dominant bit restarts the run. Cycles without `bit_stb` change nothing.
- R6: If the last reset came from hardware or software, `bus_on` becomes 1 in the cycle after the strobe that completes the first bus-free occurrence following the clearing of soft reset.
- R7: If the last reset came from bus-off, `bus_on` becomes 1 only after 128 bus-free occurrences.
- R8: The reset-cause record is set by `bus_off`. It is cleared by hardware reset, or by a write that sets bit 0 while soft reset is 0. A write of bit 0 = 1 while soft reset is already 1 leaves the record unchanged.
- R9: The dominant level on both pins equals the reverse polarity bit. A `rx_pin` equal to that bit is dominant (`rx_dom`=1). A requested dominant `tx_dom`=1 drives `tx_pin` to that bit, and otherwise `tx_pin` is its inverse.
- R10: `tx_pin` is recessive while `bus_on` is 0 or listen-only is 1.
- R11: While soft reset is 1, `bus_on` is 0 and the recovery count is cleared, so a new recovery starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 32 | Write data for the mode register |
| bus_off | input | 1 | Bus-off report from the error logic |
| bit_stb | input | 1 | One-cycle strobe marking a new sampled bit |
| rx_pin | input | 1 | Sampled receive pin level |
| tx_dom | input | 1 | Frame logic requests a dominant bit |
| rd_data | output | 32 | Mode register read value |
| soft_rst | output | 1 | Soft reset mode flag |
| listen_only | output | 1 | Listen-only mode flag |
| self_test | output | 1 | Self-test mode flag |
| prio_mode | output | 1 | Transmit priority mode flag |
| rev_pol | output | 1 | Reverse polarity flag |
| bus_on | output | 1 | Controller may take part in bus traffic |
| rx_dom | output | 1 | Receive pin decoded as dominant |
| tx_pin | output | 1 | Transmit pin level |

## Verification
The hardest state to reach is the long recovery while a reversed polarity is active. To get there, the bench raises bus-off and then rewrites the polarity while the bus-off cause is still recorded. Next it clears soft reset. It then feeds 1408 strobed bits at the low pin level, which is recessive only under reversed polarity. Along the way it checks that 127 occurrences are not enough. Another scenario leaves soft reset mid-run and re-enters it, so that a count that is not cleared would end recovery early.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  // Field positions decoded by the rest of the controller
  localparam int unsigned FLD_SRST = 0;
  localparam int unsigned FLD_LSTN = 1;
  localparam int unsigned FLD_STST = 2;
  localparam int unsigned FLD_PRIO = 3;
  localparam int unsigned FLD_RPOL = 5;

  typedef struct packed {
    logic rev_pol;
    logic prio_sel;
    logic self_test;
    logic listen_only;
    logic soft_rst;
  } mode_t;

  localparam mode_t MODE_RESET = '{rev_pol: 1'b0, prio_sel: 1'b0, self_test: 1'b0,
                                   listen_only: 1'b0, soft_rst: 1'b1};

  // A pin level is dominant when it equals the polarity bit
  function automatic logic pin_is_dom(input logic pin, input logic pol);
    return pin == pol;
  endfunction

  // Pin level for a requested bit value
  function automatic logic pin_level(input logic want_dom, input logic pol);
    return want_dom ? pol : ~pol;
  endfunction

  // Occurrences needed minus one, as a count target
  function automatic int unsigned recov_target(input logic long_cause,
                                               input int unsigned n_short,
                                               input int unsigned n_long);
    return long_cause ? (n_long - 1) : (n_short - 1);
  endfunction

endpackage

// File: rtl/can_mode_reg.sv
module can_mode_reg
  import can_mode_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          bus_off,
  output mode_t         mode,
  output logic          cause_long,
  output logic          sw_reset_ev,
  output logic          cfg_wr_ev
);

  mode_t mode_q, mode_d;
  logic  cause_q, cause_d;

  // Software enters soft reset: bit 0 written to 1 while it is 0
  assign sw_reset_ev = wr_en & ~bus_off & wr_data[FLD_SRST] & ~mode_q.soft_rst;
  // Protected fields may change only while soft reset is already set
  assign cfg_wr_ev   = wr_en & ~bus_off & mode_q.soft_rst;

  always_comb begin
    mode_d  = mode_q;
    cause_d = cause_q;
    if (bus_off) begin
      mode_d.soft_rst = 1'b1;
      cause_d         = 1'b1;
    end else if (wr_en) begin
      mode_d.soft_rst = wr_data[FLD_SRST];
      if (cfg_wr_ev) begin
        mode_d.listen_only = wr_data[FLD_LSTN];
        mode_d.self_test   = wr_data[FLD_STST];
        mode_d.prio_sel    = wr_data[FLD_PRIO];
        mode_d.rev_pol     = wr_data[FLD_RPOL];
      end
      if (sw_reset_ev) cause_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RESET;
      cause_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      cause_q <= cause_d;
    end
  end

  assign mode       = mode_q;
  assign cause_long = cause_q;

endmodule

// File: rtl/can_busfree_cnt.sv
module can_busfree_cnt
  import can_mode_pkg::*;
#(
  parameter int unsigned RUN_LEN = 11,
  parameter int unsigned N_SHORT = 1,
  parameter int unsigned N_LONG  = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic need_long,
  input  logic bit_stb,
  input  logic rx_dom,
  output logic run_done,
  output logic bus_on
);

  localparam int unsigned RUN_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam int unsigned OCC_W = (N_LONG > 1) ? $clog2(N_LONG) : 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

  logic [RUN_W-1:0] run_q;
  logic [OCC_W-1:0] occ_q;
  logic [OCC_W-1:0] occ_tgt;
  logic             on_q;
  logic             counting;
  logic             goal_hit;

  assign occ_tgt  = OCC_W'(recov_target(need_long, N_SHORT, N_LONG));
  assign counting = ~hold & ~on_q & bit_stb;
  assign run_done = counting & ~rx_dom & (run_q == RUN_LAST);
  assign goal_hit = run_done & (occ_q == occ_tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      occ_q <= '0;
      on_q  <= 1'b0;
    end else if (hold) begin
      run_q <= '0;
      occ_q <= '0;
      on_q  <= 1'b0;
    end else if (counting) begin
      if (rx_dom) begin
        run_q <= '0;
      end else if (run_done) begin
        run_q <= '0;
        if (goal_hit) on_q  <= 1'b1;
        else          occ_q <= occ_q + 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign bus_on = on_q & ~hold;

endmodule

// File: rtl/can_pin_pol.sv
module can_pin_pol
  import can_mode_pkg::*;
(
  input  logic rev_pol,
  input  logic rx_pin,
  input  logic tx_dom,
  input  logic tx_allow,
  output logic rx_dom,
  output logic tx_pin
);

  assign rx_dom = pin_is_dom(rx_pin, rev_pol);
  assign tx_pin = pin_level(tx_dom & tx_allow, rev_pol);

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned RUN_LEN = 11,
  parameter int unsigned N_SHORT = 1,
  parameter int unsigned N_LONG  = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          bus_off,
  input  logic          bit_stb,
  input  logic          rx_pin,
  input  logic          tx_dom,
  output logic [DW-1:0] rd_data,
  output logic          soft_rst,
  output logic          listen_only,
  output logic          self_test,
  output logic          prio_mode,
  output logic          rev_pol,
  output logic          bus_on,
  output logic          rx_dom,
  output logic          tx_pin
);

  mode_t mode;
  logic  cause_long;
  logic  sw_reset_ev;
  logic  cfg_wr_ev;
  logic  run_done;
  logic  tx_allow;

  can_mode_reg #(.DW(DW)) u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .bus_off     (bus_off),
    .mode        (mode),
    .cause_long  (cause_long),
    .sw_reset_ev (sw_reset_ev),
    .cfg_wr_ev   (cfg_wr_ev)
  );

  can_busfree_cnt #(.RUN_LEN(RUN_LEN), .N_SHORT(N_SHORT), .N_LONG(N_LONG)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (mode.soft_rst),
    .need_long (cause_long),
    .bit_stb   (bit_stb),
    .rx_dom    (rx_dom),
    .run_done  (run_done),
    .bus_on    (bus_on)
  );

  assign tx_allow = bus_on & ~mode.listen_only;

  can_pin_pol u_pol (
    .rev_pol  (mode.rev_pol),
    .rx_pin   (rx_pin),
    .tx_dom   (tx_dom),
    .tx_allow (tx_allow),
    .rx_dom   (rx_dom),
    .tx_pin   (tx_pin)
  );

  always_comb begin
    rd_data           = '0;
    rd_data[FLD_SRST] = mode.soft_rst;
    rd_data[FLD_LSTN] = mode.listen_only;
    rd_data[FLD_STST] = mode.self_test;
    rd_data[FLD_PRIO] = mode.prio_sel;
    rd_data[FLD_RPOL] = mode.rev_pol;
  end

  assign soft_rst    = mode.soft_rst;
  assign listen_only = mode.listen_only;
  assign self_test   = mode.self_test;
  assign prio_mode   = mode.prio_sel;
  assign rev_pol     = mode.rev_pol;

endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          bus_off,
  input logic [DW-1:0] rd_data,
  input logic          soft_rst,
  input logic          listen_only,
  input logic          self_test,
  input logic          prio_mode,
  input logic          rev_pol,
  input logic          bus_on,
  input logic          tx_pin,
  input logic          run_done,
  input logic          cause_long
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4] == 1'b0) && (rd_data[DW-1:6] == '0)); // R1

  AST_BUSOFF_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |=> (soft_rst && !bus_on)); // R3

  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_rst && !bus_off) |=> $stable({listen_only, self_test, prio_mode, rev_pol})); // R4

  AST_BUSON_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_on) |-> $past(run_done)); // R5

  AST_BUSOFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |=> cause_long); // R8

  AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_on || listen_only) |-> (tx_pin == !rev_pol)); // R10

endmodule

bind can_mode_ctrl can_mode_ctrl_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .bus_off     (bus_off),
  .rd_data     (rd_data),
  .soft_rst    (soft_rst),
  .listen_only (listen_only),
  .self_test   (self_test),
  .prio_mode   (prio_mode),
  .rev_pol     (rev_pol),
  .bus_on      (bus_on),
  .tx_pin      (tx_pin),
  .run_done    (run_done),
  .cause_long  (cause_long)
);

// File: tb/sim_can_mode_ctrl.sv
`timescale 1ns/1ps
module sim_can_mode_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        bus_off = 1'b0;
  logic        bit_stb = 1'b0;
  logic        rx_pin = 1'b1;
  logic        tx_dom = 1'b0;
  logic [31:0] rd_data;
  logic        soft_rst, listen_only, self_test, prio_mode, rev_pol;
  logic        bus_on, rx_dom, tx_pin;

  int checks = 0;
  int failures = 0;
  logic pol = 1'b0;  // bench copy of the polarity it has programmed
  bit done = 1'b0;

  always #5 clk = ~clk;

  can_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bus_off(bus_off), .bit_stb(bit_stb), .rx_pin(rx_pin), .tx_dom(tx_dom),
    .rd_data(rd_data), .soft_rst(soft_rst), .listen_only(listen_only),
    .self_test(self_test), .prio_mode(prio_mode), .rev_pol(rev_pol),
    .bus_on(bus_on), .rx_dom(rx_dom), .tx_pin(tx_pin)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic write_mode(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic send_bit(input logic recessive);
    @(negedge clk); bit_stb = 1'b1; rx_pin = recessive ? ~pol : pol;
    @(negedge clk); bit_stb = 1'b0; rx_pin = ~pol;
  endtask

  task automatic send_free(input int n);
    for (int i = 0; i < n; i++)
      for (int j = 0; j < 11; j++) send_bit(1'b1);
  endtask

  task automatic pulse_bus_off(input logic with_write);
    @(negedge clk); bus_off = 1'b1; wr_en = with_write; wr_data = '0;
    @(negedge clk); bus_off = 1'b0; wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2 read word after reset", rd_data, 32'h1);
    chk("R2 bus_on after reset", {31'b0, bus_on}, 32'h0);
    chk("R10 tx_pin recessive in reset", {31'b0, tx_pin}, 32'h1);
  endtask

  task automatic t_layout_protect;
    write_mode(32'hFFFF_FFFF);
    chk("R1 layout all ones", rd_data, 32'h2F);
    chk("R1 flags", {27'b0, rev_pol, prio_mode, self_test, listen_only, soft_rst}, 32'h1F);
    write_mode(32'h0);
    chk("R4 clear while in soft reset", rd_data, 32'h0);
    write_mode(32'h2E);
    chk("R4 protected bits kept", rd_data, 32'h0);
    write_mode(32'h01);
    chk("R4 bit 0 always writable", rd_data, 32'h1);
  endtask

  task automatic t_short_recovery;
    write_mode(32'h0);
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    chk("R5 ten recessive not enough", {31'b0, bus_on}, 32'h0);
    send_bit(1'b0);
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    chk("R5 dominant restarts run", {31'b0, bus_on}, 32'h0);
    send_bit(1'b1);
    chk("R6 bus_on after first occurrence", {31'b0, bus_on}, 32'h1);
  endtask

  task automatic t_no_strobe;
    write_mode(32'h1);
    write_mode(32'h0);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    @(negedge clk); rx_pin = pol;   // dominant level without a strobe
    repeat (3) @(negedge clk);
    rx_pin = ~pol;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    chk("R5 unstrobed cycles ignored (10 bits)", {31'b0, bus_on}, 32'h0);
    send_bit(1'b1);
    chk("R5 unstrobed cycles ignored (11 bits)", {31'b0, bus_on}, 32'h1);
  endtask

  task automatic t_tx_pol0;
    @(negedge clk); tx_dom = 1'b1;
    #1 chk("R9 tx dominant low", {31'b0, tx_pin}, 32'h0);
    @(negedge clk); tx_dom = 1'b0;
    #1 chk("R9 tx recessive high", {31'b0, tx_pin}, 32'h1);
  endtask

  task automatic t_busoff_long;
    pulse_bus_off(1'b1);
    chk("R3 soft reset forced, write dropped", rd_data, 32'h1);
    chk("R3 bus_on dropped", {31'b0, bus_on}, 32'h0);
    write_mode(32'h0);
    send_free(127);
    chk("R7 127 occurrences not enough", {31'b0, bus_on}, 32'h0);
    send_free(1);
    chk("R7 bus_on after 128 occurrences", {31'b0, bus_on}, 32'h1);
  endtask

  task automatic t_cause_kept_pol1;
    pulse_bus_off(1'b0);
    write_mode(32'h21);          // already in soft reset: cause kept
    chk("R4 polarity set in soft reset", rd_data, 32'h21);
    write_mode(32'h20);
    pol = 1'b1;
    @(negedge clk); rx_pin = 1'b1;
    #1 chk("R9 rx high is dominant when reversed", {31'b0, rx_dom}, 32'h1);
    send_free(1);
    chk("R8 cause kept, one occurrence not enough", {31'b0, bus_on}, 32'h0);
    send_free(127);
    chk("R9 reversed recessive counted to 128", {31'b0, bus_on}, 32'h1);
    @(negedge clk); tx_dom = 1'b1;
    #1 chk("R9 tx dominant high when reversed", {31'b0, tx_pin}, 32'h1);
    @(negedge clk); tx_dom = 1'b0;
  endtask

  task automatic t_cause_clear_listen;
    pulse_bus_off(1'b0);
    write_mode(32'h20);          // leave soft reset, cause still long
    write_mode(32'h23);          // software reset from 0: cause cleared
    write_mode(32'h22);
    chk("R1 listen-only read back", rd_data, 32'h22);
    send_free(1);
    chk("R8 software reset restores short recovery", {31'b0, bus_on}, 32'h1);
    @(negedge clk); tx_dom = 1'b1;
    #1 chk("R10 listen-only keeps tx recessive", {31'b0, tx_pin}, 32'h0);
    @(negedge clk); tx_dom = 1'b0;
  endtask

  task automatic t_hw_reset_cause;
    pulse_bus_off(1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    pol = 1'b0;
    chk("R2 read word after second reset", rd_data, 32'h1);
    write_mode(32'h0);
    send_free(1);
    chk("R8 hardware reset clears cause", {31'b0, bus_on}, 32'h1);
  endtask

  task automatic t_restart_count;
    write_mode(32'h1);
    chk("R11 bus_on low in soft reset", {31'b0, bus_on}, 32'h0);
    write_mode(32'h0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    write_mode(32'h1);
    write_mode(32'h0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    chk("R11 count restarted after soft reset", {31'b0, bus_on}, 32'h0);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    chk("R11 fresh 11-bit run completes", {31'b0, bus_on}, 32'h1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout_protect();
    t_short_recovery();
    t_no_strobe();
    t_tx_pol0();
    t_busoff_long();
    t_cause_kept_pol1();
    t_cause_clear_listen();
    t_hw_reset_cause();
    t_restart_count();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule